// File: doc/BRIEF.md
# Triggered Sample Pipeline with Event Buffers

This block is the digital back end of a multi-channel detector readout. Every sampling period it takes one digitized sample per channel, removes a per-channel pedestal, and writes the corrected set into a circular delay line. The delay line is long enough to cover the time the trigger system needs to decide.

When a level-1 accept arrives, the block copies a fixed-length window of past samples for all channels into one of a few event buffers. Full buffers are drained one at a time, oldest first. Each drained event appears on the output as a header word followed by one data word for every sample that passes the threshold.

While no buffer can take another event, a busy flag is raised. Triggers that arrive in that state are counted and otherwise ignored.

Top module: `trig_readout`

## Requirements
- R1: A write strobe loads a 12-bit baseline for one channel. Each stored sample equals the incoming sample minus that channel's baseline, and is 0 when the baseline is larger.
- R2: Let N be the number of sample strobes taken since reset or initialize in cycles before the accept cycle. The accepted event then holds samples N-LAT through N-LAT+WIN-1 of every channel. Samples with a negative number read as 0.
- R3: At most NBUF events are held at once.
- R4: An accept taken while busy is low starts a copy. Busy is high in the cycle after the accept, stays high during the WIN-cycle copy, and is also high while NBUF events are held.
- R5: An accept that arrives while busy is high adds one to drop_cnt. It stores nothing and produces no output words.
- R6: A header word has bit OW-1 set to 1. Its low OW-1 bits carry the number of level-1 accepts, dropped ones included, seen since reset or initialize before this event's accept.
- R7: A data word has bit OW-1 set to 0. Below that bit sit the channel number (CHW bits), then the sample index within the window (IDXW bits), then the 12-bit corrected value in the lowest bits.
- R8: A data word is emitted only when its value is at or above thresh. Within an event, words come in index order, and in channel order within each index.
- R9: Events are read out in the order they were accepted. Each event is one header followed by its data words.
- R10: Initialize clears the delay line to zero and discards held events. It also clears the trigger and drop counts and lowers busy. Baselines are kept.
- R11: After reset, busy, out_valid and drop_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Initialize: clears delay line, buffers and counters |
| smp_valid | input | 1 | One strobe per sampling period |
| smp_data | input | NCH*SW | Samples of all channels, channel c at bits c*SW |
| bl_we | input | 1 | Baseline write strobe |
| bl_ch | input | CHW | Channel selected for the baseline write |
| bl_val | input | SW | Baseline value |
| thresh | input | SW | Zero-suppression threshold |
| l1a | input | 1 | Level-1 accept pulse |
| busy | output | 1 | No buffer can take a trigger |
| drop_cnt | output | DCW | Triggers refused while busy |
| out_valid | output | 1 | out_word carries a word |
| out_word | output | OW | Header or data word |

## Verification
The bench triggers before the delay line has filled. A design that reads the wrong slot or skips the clearing would then emit stale samples where zeros are expected.

A baseline above every sample exposes a subtraction that wraps instead of clamping. A dense train of triggers fills every buffer and lands accepts during copies. An off-by-one in the full test would then overwrite a held event, or count drops that never happened.

Initialize is pulsed while a copy is in flight, so leftover state would show up as a stray event or an unreset header count.

// File: rtl/trg_pkg.sv
package trg_pkg;
  typedef enum logic [0:0] {RD_IDLE, RD_SCAN} rd_state_t;

  // circular step of p by d inside [0, m)
  function automatic int ring_step(int p, int d, int m);
    int r;
    r = (p + d) % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  // pedestal removal clamped at zero
  function automatic int sat_diff(int a, int b);
    return (a > b) ? a - b : 0;
  endfunction
endpackage

// File: rtl/trg_pipe.sv
module trg_pipe
  import trg_pkg::*;
#(
  parameter int NCH   = 64,
  parameter int SW    = 12,
  parameter int DEPTH = 160,
  parameter int CHW   = 6,
  parameter int PW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               smp_valid,
  input  logic [NCH*SW-1:0]  smp_data,
  input  logic               bl_we,
  input  logic [CHW-1:0]     bl_ch,
  input  logic [SW-1:0]      bl_val,
  input  logic [PW-1:0]      rd_addr,
  output logic [NCH*SW-1:0]  rd_word,
  output logic [PW-1:0]      wptr
);
  logic [SW-1:0]     base_q [NCH];
  logic [NCH*SW-1:0] line_q [DEPTH];
  logic [NCH*SW-1:0] corr;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      corr[c*SW +: SW] = SW'(sat_diff(int'(smp_data[c*SW +: SW]), int'(base_q[c])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) base_q[c] <= '0;
    end else if (bl_we) begin
      base_q[bl_ch] <= bl_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      wptr <= '0;
      for (int d = 0; d < DEPTH; d++) line_q[d] <= '0;
    end else if (smp_valid) begin
      line_q[wptr] <= corr;
      wptr <= PW'(ring_step(int'(wptr), 1, DEPTH));
    end
  end

  assign rd_word = line_q[rd_addr];
endmodule

// File: rtl/trg_evbuf.sv
module trg_evbuf
  import trg_pkg::*;
#(
  parameter int NCH   = 64,
  parameter int SW    = 12,
  parameter int DEPTH = 160,
  parameter int LAT   = 150,
  parameter int WIN   = 8,
  parameter int NBUF  = 5,
  parameter int PW    = 8,
  parameter int IDXW  = 3,
  parameter int BW    = 3,
  parameter int OCW   = 3,
  parameter int TW    = 21,
  parameter int DCW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               l1a,
  input  logic [PW-1:0]      wptr,
  output logic [PW-1:0]      pipe_addr,
  input  logic [NCH*SW-1:0]  pipe_word,
  input  logic               release_ev,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [NCH*SW-1:0]  ev_word,
  output logic [TW-1:0]      head_tag,
  output logic [OCW-1:0]     occ,
  output logic               busy,
  output logic               accept_fire,
  output logic               copy_done,
  output logic [DCW-1:0]     drop_cnt
);
  logic              copying;
  logic [IDXW-1:0]   k;
  logic [PW-1:0]     src;
  logic [BW-1:0]     wr_slot, rd_slot;
  logic [TW-1:0]     tcnt;
  logic [TW-1:0]     tag_q [NBUF];
  logic [NCH*SW-1:0] ev_q  [NBUF*WIN];
  logic              drop_fire;

  assign busy        = copying || (occ == OCW'(NBUF));
  assign accept_fire = l1a && !busy;
  assign drop_fire   = l1a && busy;
  assign copy_done   = copying && (k == IDXW'(WIN-1));
  assign pipe_addr   = src;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      copying  <= 1'b0;
      k        <= '0;
      src      <= '0;
      wr_slot  <= '0;
      rd_slot  <= '0;
      occ      <= '0;
      tcnt     <= '0;
      drop_cnt <= '0;
    end else begin
      if (l1a)       tcnt     <= tcnt + 1'b1;
      if (drop_fire) drop_cnt <= drop_cnt + 1'b1;
      if (accept_fire) begin
        copying <= 1'b1;
        k       <= '0;
        src     <= PW'(ring_step(int'(wptr), -LAT, DEPTH));
      end
      if (copying) begin
        src <= PW'(ring_step(int'(src), 1, DEPTH));
        k   <= k + 1'b1;
        if (copy_done) begin
          copying <= 1'b0;
          wr_slot <= BW'(ring_step(int'(wr_slot), 1, NBUF));
        end
      end
      if (release_ev) rd_slot <= BW'(ring_step(int'(rd_slot), 1, NBUF));
      occ <= occ + OCW'(copy_done) - OCW'(release_ev);
    end
  end

  always_ff @(posedge clk) begin
    if (accept_fire) tag_q[wr_slot] <= tcnt;
    if (copying) ev_q[int'(wr_slot)*WIN + int'(k)] <= pipe_word;
  end

  assign ev_word  = ev_q[int'(rd_slot)*WIN + int'(rd_idx)];
  assign head_tag = tag_q[rd_slot];
endmodule

// File: rtl/trg_scan.sv
module trg_scan
  import trg_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int SW   = 12,
  parameter int WIN  = 8,
  parameter int CHW  = 6,
  parameter int IDXW = 3,
  parameter int OCW  = 3,
  parameter int TW   = 21,
  parameter int OW   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [OCW-1:0]    occ,
  input  logic [TW-1:0]     head_tag,
  input  logic [NCH*SW-1:0] ev_word,
  input  logic [SW-1:0]     thresh,
  output logic [IDXW-1:0]   rd_idx,
  output logic              release_ev,
  output logic              out_valid,
  output logic [OW-1:0]     out_word
);
  rd_state_t      st;
  logic [CHW-1:0] ch;
  logic [IDXW-1:0] idx;
  logic [SW-1:0]  cur;
  logic           ch_last;

  function automatic logic [OW-1:0] hdr_word(logic [TW-1:0] tag);
    return {1'b1, tag};
  endfunction

  function automatic logic [OW-1:0] data_word(logic [CHW-1:0] c, logic [IDXW-1:0] i,
                                              logic [SW-1:0] v);
    return {1'b0, c, i, v};
  endfunction

  assign cur        = ev_word[int'(ch)*SW +: SW];
  assign ch_last    = (ch == CHW'(NCH-1));
  assign release_ev = (st == RD_SCAN) && ch_last && (idx == IDXW'(WIN-1));
  assign rd_idx     = idx;

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      st        <= RD_IDLE;
      ch        <= '0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          out_valid <= 1'b0;
          if (occ != '0) begin
            out_valid <= 1'b1;
            out_word  <= hdr_word(head_tag);
            ch        <= '0;
            idx       <= '0;
            st        <= RD_SCAN;
          end
        end
        default: begin
          out_valid <= (cur >= thresh);
          out_word  <= data_word(ch, idx, cur);
          if (ch_last) begin
            ch <= '0;
            if (release_ev) st  <= RD_IDLE;
            else            idx <= idx + 1'b1;
          end else begin
            ch <= ch + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/trig_readout.sv
module trig_readout
  import trg_pkg::*;
#(
  parameter int NCH   = 64,
  parameter int SW    = 12,
  parameter int DEPTH = 160,
  parameter int LAT   = 150,
  parameter int WIN   = 8,
  parameter int NBUF  = 5,
  parameter int DCW   = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int OCW  = $clog2(NBUF + 1),
  localparam int OW   = 1 + CHW + IDXW + SW,
  localparam int TW   = OW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              smp_valid,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic              bl_we,
  input  logic [CHW-1:0]    bl_ch,
  input  logic [SW-1:0]     bl_val,
  input  logic [SW-1:0]     thresh,
  input  logic              l1a,
  output logic              busy,
  output logic [DCW-1:0]    drop_cnt,
  output logic              out_valid,
  output logic [OW-1:0]     out_word
);
  // named internal events, observed by the bound checker
  logic              accept_fire;
  logic              copy_done;
  logic              release_ev;
  logic [OCW-1:0]    occ;
  logic [PW-1:0]     wptr, pipe_addr;
  logic [NCH*SW-1:0] pipe_word, ev_word;
  logic [TW-1:0]     head_tag;
  logic [IDXW-1:0]   rd_idx;

  trg_pipe #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .CHW(CHW), .PW(PW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .init(init),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .bl_we(bl_we), .bl_ch(bl_ch), .bl_val(bl_val),
    .rd_addr(pipe_addr), .rd_word(pipe_word), .wptr(wptr)
  );

  trg_evbuf #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .LAT(LAT), .WIN(WIN), .NBUF(NBUF),
              .PW(PW), .IDXW(IDXW), .BW(BW), .OCW(OCW), .TW(TW), .DCW(DCW)) u_evbuf (
    .clk(clk), .rst_n(rst_n), .init(init), .l1a(l1a),
    .wptr(wptr), .pipe_addr(pipe_addr), .pipe_word(pipe_word),
    .release_ev(release_ev), .rd_idx(rd_idx), .ev_word(ev_word),
    .head_tag(head_tag), .occ(occ), .busy(busy),
    .accept_fire(accept_fire), .copy_done(copy_done), .drop_cnt(drop_cnt)
  );

  trg_scan #(.NCH(NCH), .SW(SW), .WIN(WIN), .CHW(CHW), .IDXW(IDXW),
             .OCW(OCW), .TW(TW), .OW(OW)) u_scan (
    .clk(clk), .rst_n(rst_n), .init(init),
    .occ(occ), .head_tag(head_tag), .ev_word(ev_word), .thresh(thresh),
    .rd_idx(rd_idx), .release_ev(release_ev),
    .out_valid(out_valid), .out_word(out_word)
  );
endmodule

// File: rtl/trig_readout_chk.sv
module trig_readout_chk #(
  parameter int NBUF = 5,
  parameter int SW   = 12,
  parameter int OW   = 22,
  parameter int OCW  = 3,
  parameter int DCW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           init,
  input logic           l1a,
  input logic           busy,
  input logic [DCW-1:0] drop_cnt,
  input logic [OCW-1:0] occ,
  input logic           accept_fire,
  input logic           copy_done,
  input logic           release_ev,
  input logic [SW-1:0]  thresh,
  input logic           out_valid,
  input logic [OW-1:0]  out_word
);
  assert_occ_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCW'(NBUF));

  assert_occ_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && !release_ev && !init) |=> occ == OCW'($past(occ) + 1'b1));

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fire && !init) |=> busy);

  assert_drop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1a && busy && !init) |=> drop_cnt == DCW'($past(drop_cnt) + 1'b1));

  assert_hdr_has_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[OW-1]) |-> occ != '0);

  assert_zs_threshold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_word[OW-1]) |-> out_word[SW-1:0] >= $past(thresh));
endmodule

bind trig_readout trig_readout_chk #(.NBUF(NBUF), .SW(SW), .OW(OW), .OCW(OCW), .DCW(DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .l1a(l1a), .busy(busy), .drop_cnt(drop_cnt),
  .occ(occ), .accept_fire(accept_fire), .copy_done(copy_done), .release_ev(release_ev),
  .thresh(thresh), .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_trig_readout.sv
module sim_trig_readout;
  localparam int NCH = 4, SW = 12, DEPTH = 16, LAT = 12, WIN = 4, NBUF = 5, DCW = 16;
  localparam int OW = 1 + 2 + 2 + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0, init = 1'b0, smp_valid = 1'b0, bl_we = 1'b0, l1a = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic [1:0] bl_ch = '0;
  logic [SW-1:0] bl_val = '0, thresh = '0;
  logic busy, out_valid;
  logic [DCW-1:0] drop_cnt;
  logic [OW-1:0] out_word;

  always #2 clk = ~clk;

  trig_readout #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .LAT(LAT), .WIN(WIN),
                 .NBUF(NBUF), .DCW(DCW)) u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .smp_valid(smp_valid), .smp_data(smp_data),
    .bl_we(bl_we), .bl_ch(bl_ch), .bl_val(bl_val), .thresh(thresh), .l1a(l1a),
    .busy(busy), .drop_cnt(drop_cnt), .out_valid(out_valid), .out_word(out_word)
  );

  int errors = 0, checks = 0;
  int hist [0:511][0:NCH-1];
  int bl_m [NCH];
  int nsamp = 0, tcnt_m = 0, drops_m = 0;
  bit busy_seen = 0;
  logic [OW-1:0] exp_q[$], got_q[$];

  always @(negedge clk) if (rst_n && out_valid) got_q.push_back(out_word);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int raw(int n, int c);
    return (n * 149 + c * 997 + 53) % 4096;
  endfunction

  task automatic push_event(input int n, input int tag);
    exp_q.push_back({1'b1, 16'(tag)});
    for (int i = 0; i < WIN; i++)
      for (int c = 0; c < NCH; c++) begin
        int s, v;
        s = n - LAT + i;
        v = (s < 0) ? 0 : hist[s][c];
        if (v >= int'(thresh)) exp_q.push_back({1'b0, 2'(c), 2'(i), 12'(v)});
      end
  endtask

  task automatic cyc(input bit sv, input bit l1);
    @(negedge clk);
    smp_valid = sv;
    l1a = l1;
    for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = SW'(raw(nsamp, c));
    if (busy) busy_seen = 1;
    if (l1) begin
      if (busy) drops_m++;
      else push_event(nsamp, tcnt_m);
      tcnt_m++;
    end
    if (sv) begin
      for (int c = 0; c < NCH; c++)
        hist[nsamp][c] = (raw(nsamp, c) > bl_m[c]) ? raw(nsamp, c) - bl_m[c] : 0;
      nsamp++;
    end
  endtask

  task automatic set_base(input int c, input int v);
    @(negedge clk);
    bl_we = 1; bl_ch = 2'(c); bl_val = SW'(v);
    @(negedge clk);
    bl_we = 0;
    bl_m[c] = v;
  endtask

  task automatic drain_and_compare(input string tagmsg);
    int n;
    repeat (NBUF * (NCH * WIN + 3) + 20) cyc(0, 0);
    check(got_q.size() == exp_q.size(), {"R9 word count ", tagmsg}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      check(got_q[i] == exp_q[i],
            exp_q[i][OW-1] ? {"R6 R9 header ", tagmsg} : {"R2 R7 R8 data ", tagmsg},
            int'(got_q[i]), int'(exp_q[i]));
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) bl_m[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R11 busy after reset", busy, 0);
    check(out_valid == 0, "R11 out_valid after reset", out_valid, 0);
    check(drop_cnt == 0, "R11 drop_cnt after reset", drop_cnt, 0);

    // baselines: zero, mid, above every sample, large
    set_base(1, 300);
    set_base(2, 4095);
    set_base(3, 1000);

    // phase A: all samples kept, one trigger before the line has filled
    thresh = 0;
    for (int t = 0; t < 40; t++) cyc(1, (t == 5) || (t == 20) || (t == 33));
    drain_and_compare("phaseA");
    begin
      int bad;
      bad = 0;
      foreach (got_q[i])
        if (!got_q[i][OW-1] && got_q[i][OW-2 -: 2] == 2'd2 && got_q[i][SW-1:0] != 0) bad++;
      check(bad == 0, "R1 clamped channel stays zero", bad, 0);
    end
    got_q.delete(); exp_q.delete();

    // phase B: threshold suppression
    thresh = 12'd1500;
    for (int t = 0; t < 30; t++) cyc(1, (t == 4) || (t == 19));
    drain_and_compare("phaseB");
    begin
      int low;
      low = 0;
      foreach (got_q[i]) if (!got_q[i][OW-1] && got_q[i][SW-1:0] < 1500) low++;
      check(low == 0, "R8 no word below threshold", low, 0);
    end
    got_q.delete(); exp_q.delete();

    // phase C: trigger every cycle, fills buffers and lands accepts in copies
    thresh = 12'd3000;
    busy_seen = 0;
    for (int t = 0; t < 60; t++) cyc(1, 1'b1);
    cyc(1, 0);
    check(busy_seen == 1, "R4 busy raised under trigger burst", busy_seen, 1);
    check(drops_m > 0, "R5 burst produced refused triggers", drops_m, 1);
    drain_and_compare("phaseC");
    check(drop_cnt == DCW'(drops_m), "R5 drop count", drop_cnt, drops_m);
    check(busy == 0, "R3 buffers drained", busy, 0);
    got_q.delete(); exp_q.delete();

    // phase D: initialize during a copy
    thresh = 0;
    cyc(1, 1);
    cyc(0, 0);
    @(negedge clk);
    l1a = 0; smp_valid = 0; init = 1;
    @(negedge clk);
    init = 0;
    nsamp = 0; tcnt_m = 0; drops_m = 0;
    exp_q.delete();
    check(busy == 0, "R10 busy after init", busy, 0);
    check(drop_cnt == 0, "R10 drop count after init", drop_cnt, 0);
    cyc(0, 1);
    for (int t = 0; t < 24; t++) cyc(1, t == 20);
    drain_and_compare("phaseD");
    check(got_q.size() > 0 && got_q[0] == {1'b1, 16'd0}, "R10 header count restarts",
          (got_q.size() > 0) ? int'(got_q[0]) : -1, 1 << (OW-1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule